// File: doc/BRIEF.md
# Streaming Quadratic Polynomial Evaluator

This block evaluates the second-order polynomial y = A·x² + B·x + C on a stream of signed samples. It is fully spatial: three multipliers and two adders each have a fixed job and all work at once, so one sample can be accepted on every clock. Registers split the arithmetic into three stages, and each result leaves the block three clocks after its sample went in. The clock period is bounded by one multiplier plus a few register overheads, not by the whole polynomial.

The three coefficients live in configuration registers that are written through a plain load strobe. Samples arrive as `x_in` qualified by `x_valid`; results leave as `y_out` qualified by `y_valid`. The stream has no back-pressure: there is no ready signal, the input side is always ready, and the consumer must take every result in the cycle `y_valid` is high. All arithmetic is two's complement, and `y_out` is wide enough that no coefficient or sample value can wrap.

Top module: `quad_eval`

## Requirements
- R1: While `rst` is high at a rising edge, every valid stage is cleared, so `y_valid` is low in the cycle after reset is released, even if `x_valid` was high during reset. The coefficient registers reset to zero.
- R2: A sample accepted (`x_valid` high) at rising edge k produces `y_valid` high after rising edge k+2, that is, three clocks of latency counting the capture edge. There is no other latency.
- R3: `y_out` equals A·x² + B·x + C exactly, computed as signed two's-complement integers at full width YW = 2·XW + CW + 1, with no truncation or wrap.
- R4: Samples on consecutive edges give results on consecutive cycles: throughput is one result per clock.
- R5: Results leave in the order their samples entered, and every accepted sample gives exactly one result.
- R6: A cycle with `x_valid` low produces a cycle with `y_valid` low three clocks later; the value on `x_in` in such a cycle has no effect on any result.
- R7: A rising edge with `cfg_we` high loads `cfg_a`, `cfg_b` and `cfg_c`. Samples accepted on an earlier edge finish with the old coefficients; samples accepted on a later edge use only the new ones.
- R8: The extreme operand values (most negative and most positive x and coefficients) give the exact mathematical result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load strobe for the three coefficient registers |
| cfg_a | input | CW | Signed coefficient of x² |
| cfg_b | input | CW | Signed coefficient of x |
| cfg_c | input | CW | Signed constant term |
| x_valid | input | 1 | Sample qualifier; the block is always ready |
| x_in | input | XW | Signed sample |
| y_valid | output | 1 | Result qualifier, three clocks after its sample |
| y_out | output | 2·XW+CW+1 | Signed polynomial result |

## Verification
The bench builds the block with XW = 8 and CW = 8, giving a 25-bit result. At that width the most negative and most positive samples and coefficients can be driven directly, so the full-range sign extension through every multiplier and adder is exercised, while the expected values still fit in a 64-bit model. The short widths also keep back-to-back streams, bubble patterns and a coefficient reload in the middle of a stream cheap enough to run as several distinct scenarios.

// File: rtl/quad_pkg.sv
package quad_pkg;

  // Width of a signed sum of two signed operands, one guard bit.
  function automatic int sum_width(input int aw, input int bw);
    return ((aw > bw) ? aw : bw) + 1;
  endfunction

  // Width of the full quadratic result for XW-bit samples, CW-bit coefficients.
  function automatic int result_width(input int xw, input int cw);
    int axx_w;
    int bxc_w;
    axx_w = 2 * xw + cw;
    bxc_w = sum_width(xw + cw, cw);
    return sum_width(axx_w, bxc_w);
  endfunction

  // Number of register stages from sample capture to result.
  localparam int STAGES = 3;

endpackage

// File: rtl/quad_mul.sv
module quad_mul #(
  parameter int AW = 8,
  parameter int BW = 8,
  localparam int PW = AW + BW
) (
  input  logic signed [AW-1:0] a,
  input  logic signed [BW-1:0] b,
  output logic signed [PW-1:0] p
);
  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  always_comb begin
    a_ext = PW'(a);
    b_ext = PW'(b);
    p     = a_ext * b_ext;
  end
endmodule

// File: rtl/quad_add.sv
module quad_add #(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter int OW = 9
) (
  input  logic signed [AW-1:0] a,
  input  logic signed [BW-1:0] b,
  output logic signed [OW-1:0] s
);
  logic signed [OW-1:0] a_ext;
  logic signed [OW-1:0] b_ext;

  always_comb begin
    a_ext = OW'(a);
    b_ext = OW'(b);
    s     = a_ext + b_ext;
  end
endmodule

// File: rtl/quad_pipe_reg.sv
module quad_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Data stage register: no reset, loads only when its stage carries a sample.
  always_ff @(posedge clk) begin
    if (en) q <= d;
  end
endmodule

// File: rtl/quad_valid_chain.sv
module quad_valid_chain #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vin,
  output logic [DEPTH-1:0] vstage
);
  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) vstage[0] <= 1'b0;
          else     vstage[0] <= vin;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) vstage[i] <= 1'b0;
          else     vstage[i] <= vstage[i-1];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/quad_coef_regs.sv
module quad_coef_regs #(
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic signed [CW-1:0] a_in,
  input  logic signed [CW-1:0] b_in,
  input  logic signed [CW-1:0] c_in,
  output logic signed [CW-1:0] a_q,
  output logic signed [CW-1:0] b_q,
  output logic signed [CW-1:0] c_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (we) begin
      a_q <= a_in;
      b_q <= b_in;
      c_q <= c_in;
    end
  end
endmodule

// File: rtl/quad_eval.sv
module quad_eval #(
  parameter int XW = 16,
  parameter int CW = 16,
  localparam int YW = quad_pkg::result_width(XW, CW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic signed [CW-1:0] cfg_a,
  input  logic signed [CW-1:0] cfg_b,
  input  logic signed [CW-1:0] cfg_c,
  input  logic                 x_valid,
  input  logic signed [XW-1:0] x_in,
  output logic                 y_valid,
  output logic signed [YW-1:0] y_out
);
  localparam int NSTG  = quad_pkg::STAGES;
  localparam int SQW   = 2 * XW;
  localparam int BXW   = XW + CW;
  localparam int AXXW  = SQW + CW;
  localparam int BXCW  = quad_pkg::sum_width(BXW, CW);

  logic signed [CW-1:0] coef_a, coef_b, coef_c;
  logic [NSTG-1:0]      vst;

  // Stage 1 combinational results and registers
  logic signed [SQW-1:0] sq_d,  sq_q;
  logic signed [BXW-1:0] bx_d,  bx_q;
  logic signed [CW-1:0]  cpass_q;
  // Stage 2
  logic signed [AXXW-1:0] axx_d, axx_q;
  logic signed [BXCW-1:0] bxc_d, bxc_q;
  // Stage 3
  logic signed [YW-1:0]   sum_d, sum_q;

  quad_coef_regs #(.CW(CW)) u_coef (
    .clk (clk), .rst (rst), .we (cfg_we),
    .a_in (cfg_a), .b_in (cfg_b), .c_in (cfg_c),
    .a_q (coef_a), .b_q (coef_b), .c_q (coef_c)
  );

  quad_valid_chain #(.DEPTH(NSTG)) u_vchain (
    .clk (clk), .rst (rst), .vin (x_valid), .vstage (vst)
  );

  // ---- stage 1: x*x, B*x, carry C ----
  quad_mul #(.AW(XW), .BW(XW)) u_mul_sq (.a(x_in),   .b(x_in), .p(sq_d));
  quad_mul #(.AW(CW), .BW(XW)) u_mul_bx (.a(coef_b), .b(x_in), .p(bx_d));

  quad_pipe_reg #(.W(SQW)) u_r_sq (.clk(clk), .en(x_valid), .d(sq_d),   .q(sq_q));
  quad_pipe_reg #(.W(BXW)) u_r_bx (.clk(clk), .en(x_valid), .d(bx_d),   .q(bx_q));
  quad_pipe_reg #(.W(CW))  u_r_c  (.clk(clk), .en(x_valid), .d(coef_c), .q(cpass_q));

  // ---- stage 2: A*(x*x), (B*x)+C ----
  quad_mul #(.AW(CW), .BW(SQW)) u_mul_axx (.a(coef_a), .b(sq_q), .p(axx_d));
  quad_add #(.AW(BXW), .BW(CW), .OW(BXCW)) u_add_bxc (.a(bx_q), .b(cpass_q), .s(bxc_d));

  quad_pipe_reg #(.W(AXXW)) u_r_axx (.clk(clk), .en(vst[0]), .d(axx_d), .q(axx_q));
  quad_pipe_reg #(.W(BXCW)) u_r_bxc (.clk(clk), .en(vst[0]), .d(bxc_d), .q(bxc_q));

  // ---- stage 3: final sum ----
  quad_add #(.AW(AXXW), .BW(BXCW), .OW(YW)) u_add_y (.a(axx_q), .b(bxc_q), .s(sum_d));

  quad_pipe_reg #(.W(YW)) u_r_y (.clk(clk), .en(vst[1]), .d(sum_d), .q(sum_q));

  assign y_valid = vst[NSTG-1];
  assign y_out   = sum_q;
endmodule

// File: rtl/quad_eval_chk.sv
module quad_eval_chk #(
  parameter int XW = 16,
  parameter int CW = 16,
  localparam int YW = quad_pkg::result_width(XW, CW)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic signed [CW-1:0] cfg_a,
  input logic signed [CW-1:0] cfg_b,
  input logic signed [CW-1:0] cfg_c,
  input logic                 x_valid,
  input logic signed [XW-1:0] x_in,
  input logic                 y_valid,
  input logic signed [YW-1:0] y_out
);
  logic [2:0] since_rst;
  logic [2:0] since_cfg;
  logic signed [CW-1:0] ca, cb, cc;
  logic signed [XW-1:0] xh1, xh2, xh3;
  logic signed [YW-1:0] y_model;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      since_cfg <= '0;
      ca <= '0; cb <= '0; cc <= '0;
    end else begin
      if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
      if (cfg_we) begin
        since_cfg <= '0;
        ca <= cfg_a; cb <= cfg_b; cc <= cfg_c;
      end else if (since_cfg != 3'd7) begin
        since_cfg <= since_cfg + 3'd1;
      end
    end
    xh1 <= x_in;
    xh2 <= xh1;
    xh3 <= xh2;
  end

  always_comb begin
    y_model = YW'(ca) * YW'(xh3) * YW'(xh3) + YW'(cb) * YW'(xh3) + YW'(cc);
  end

  // R1: first cycle out of reset carries no result
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !y_valid);

  // R2 / R6: output qualifier is the input qualifier three clocks earlier
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd3) |-> (y_valid == $past(x_valid, 3)));

  // R3: value matches the polynomial when coefficients were quiet
  a_r3_value: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd3 && since_cfg >= 3'd3 && y_valid) |-> (y_out == y_model));

  // R4: back-to-back samples give back-to-back results
  a_r4_rate: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && $past(x_valid, 3) && $past(x_valid, 4)) |-> (y_valid && $past(y_valid)));
endmodule

bind quad_eval quad_eval_chk #(.XW(XW), .CW(CW)) u_chk (
  .clk (clk), .rst (rst), .cfg_we (cfg_we),
  .cfg_a (cfg_a), .cfg_b (cfg_b), .cfg_c (cfg_c),
  .x_valid (x_valid), .x_in (x_in),
  .y_valid (y_valid), .y_out (y_out)
);

// File: tb/quad_eval_tb.sv
module quad_eval_tb;
  localparam int XW = 8;
  localparam int CW = 8;
  localparam int YW = quad_pkg::result_width(XW, CW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic signed [CW-1:0] cfg_a = '0, cfg_b = '0, cfg_c = '0;
  logic x_valid = 1'b0;
  logic signed [XW-1:0] x_in = '0;
  logic y_valid;
  logic signed [YW-1:0] y_out;

  int checks = 0;
  int fails  = 0;
  longint ma = 0, mb = 0, mc = 0;
  longint expq[$];
  string  tagq[$];
  logic [2:0] vh = '0;
  bit mon_on = 1'b0;

  always #5 clk = ~clk;

  quad_eval #(.XW(XW), .CW(CW)) u_dut (
    .clk (clk), .rst (rst), .cfg_we (cfg_we),
    .cfg_a (cfg_a), .cfg_b (cfg_b), .cfg_c (cfg_c),
    .x_valid (x_valid), .x_in (x_in),
    .y_valid (y_valid), .y_out (y_out)
  );

  function automatic longint poly(longint a, longint b, longint c, longint x);
    return a * x * x + b * x + c;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Valid history of captured samples (reset clears the chain)
  always @(posedge clk) vh <= {vh[1:0], x_valid & ~rst};

  // Result monitor: qualifier timing and values in order
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      check("R2/R6 valid timing", y_valid, vh[2]);
      if (y_valid) begin
        if (expq.size() == 0) check("R5 unexpected result", 1, 0);
        else begin
          string t;
          longint e;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(t, longint'(y_out), e);
        end
      end
    end
  end

  task automatic push(input logic signed [XW-1:0] x, input string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    x_valid = 1'b1;
    x_in = x;
    expq.push_back(poly(ma, mb, mc, longint'(x)));
    tagq.push_back(tag);
  endtask

  task automatic idle(input int n, input logic signed [XW-1:0] junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      x_valid = 1'b0;
      x_in = junk;
    end
  endtask

  task automatic load(input longint a, input longint b, input longint c);
    @(negedge clk);
    x_valid = 1'b0;
    cfg_we = 1'b1;
    cfg_a = CW'(a); cfg_b = CW'(b); cfg_c = CW'(c);
    ma = a; mb = b; mc = c;
  endtask

  task automatic drain();
    idle(5, '0);
    check("R5 all results delivered", expq.size(), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    x_valid = 1'b1;
    x_in = 8'sd5;
    repeat (4) @(negedge clk);
    x_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 y_valid after reset", y_valid, 0);
    // coefficients reset to zero: result of any sample is 0
    mon_on = 1'b1;
    push(8'sd77, "R1 zero coefficients");
    drain();
  endtask

  task automatic t_latency();
    load(3, -2, 5);
    push(8'sd4, "R3 single value");
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      x_valid = 1'b0;
      if (k < 3) check("R2 not yet valid", y_valid, 0);
      else       check("R2 valid on third clock", y_valid, 1);
    end
    drain();
  endtask

  task automatic t_stream();
    load(-7, 11, -100);
    for (int i = -20; i <= 20; i += 3) push(XW'(i), "R4 R5 R3 stream");
    push(8'sd127, "R4 stream tail");
    drain();
  endtask

  task automatic t_bubbles();
    load(2, 9, 1);
    push(8'sd10, "R6 before gap");
    idle(1, 8'sd99);
    push(-8'sd3, "R6 after gap");
    push(8'sd6, "R6 pair");
    idle(2, -8'sd55);
    push(8'sd1, "R6 after long gap");
    drain();
  endtask

  task automatic t_extremes();
    load(-128, -128, -128);
    push(-8'sd128, "R8 all most negative");
    push(8'sd127, "R8 x max, coef min");
    load(127, 127, 127);
    push(-8'sd128, "R8 coef max, x min");
    push(8'sd127, "R8 all most positive");
    load(127, -128, 127);
    push(-8'sd128, "R8 mixed signs");
    push(8'sd0, "R8 zero sample");
    drain();
  endtask

  task automatic t_reconfig();
    load(1, 1, 1);
    push(8'sd5, "R7 old coefficients");
    push(-8'sd6, "R7 old coefficients in flight");
    load(-4, 3, 50);
    push(8'sd5, "R7 new coefficients");
    push(-8'sd6, "R7 new coefficients back-to-back");
    drain();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    t_reset();
    t_latency();
    t_stream();
    t_bubbles();
    t_extremes();
    t_reconfig();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule